// File: doc/BRIEF.md
# Satellite LNB control tone keyer

This block drives the on/off gate of a 22 kHz carrier used to control a satellite low-noise block and its switches. On a start strobe it captures a message of up to `MAX_LEN` bytes and an optional burst selection. It then keys the gate through a leading quiet period, the message bytes, a trailing quiet period and the optional burst. Each byte uses pulse-width symbols and ends with an odd parity bit. The carrier generator downstream is simply enabled whenever the gate is high.

Two burst forms exist. The tone burst holds the gate high for a fixed interval. The byte burst sends the byte 0xFF with its parity bit, using the normal symbol coding. Either burst is followed by a settling period before the block reports completion. While no transfer is running, the gate follows a continuous-tone enable. All durations are given in microseconds and scaled by a clock-ticks-per-microsecond parameter.

Top module: `lnbk_tone_keyer`

## Requirements
- R1: Out of reset, `gate`, `busy` and `done` are 0. While idle, `gate` equals the `tone_en` value sampled at the previous clock edge.
- R2: A `start` seen while idle captures `msg_len`, `msg_bytes` and `burst_sel`, and `busy` is 1 from the next cycle on. While busy, `start`, `msg_len`, `msg_bytes`, `burst_sel` and `tone_en` have no effect on the gate waveform.
- R3: A 1 symbol is the gate high for `BIT_SHORT_US` then low for `BIT_LONG_US`. A 0 symbol is high for `BIT_LONG_US` then low for `BIT_SHORT_US`. One microsecond is `TICKS_PER_US` clock cycles.
- R4: Bytes go out in order byte 0 first, where byte k is `msg_bytes[8k+7:8k]`, each most significant bit first. Each byte is followed by a parity bit chosen so that the nine bits hold an odd number of ones.
- R5: The gate is low for `GAP_US` before the first byte and again for `GAP_US` after the last byte.
- R6: With `burst_sel` = 2'b10, the trailing quiet period is followed by the byte 0xFF with its parity bit, in the coding of R3.
- R7: With `burst_sel` = 2'b01, the trailing quiet period is followed by the gate held high for `TONE_BURST_US`.
- R8: After either burst the gate stays low for `SETTLE_US` before completion. With `burst_sel` 2'b00 or 2'b11 there is no burst and no settling period.
- R9: A `msg_len` above `MAX_LEN` is treated as `MAX_LEN`.
- R10: `done` is high for exactly one cycle, in the first cycle in which `busy` is 0 after a transfer.
- R11: A `msg_len` of 0 sends only the two quiet periods and the selected burst, if any.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| msg_len | input | $clog2(MAX_LEN+1)+1 | Number of message bytes |
| msg_bytes | input | MAX_LEN*8 | Message bytes, byte 0 in the low bits |
| burst_sel | input | 2 | 00 none, 01 tone burst, 10 byte burst, 11 none |
| tone_en | input | 1 | Continuous tone request while idle |
| gate | output | 1 | Carrier enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The gate is registered, so the first waveform cycle appears one clock after the edge that samples `start`. From then on, each phase lasts exactly its duration in microseconds times `TICKS_PER_US` cycles. The bench builds the whole expected waveform cycle by cycle from the requirements. It compares `gate` and `busy` at every falling edge, starting with the first cycle after the start edge. `done` is expected in the cycle immediately after the last waveform cycle, and is checked low again one cycle later. The idle tone path has one register, so it is checked one cycle after `tone_en` changes.

// File: rtl/lnbk_pkg.sv
package lnbk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_MARK,
    ST_SPACE,
    ST_TRAIL,
    ST_TONE,
    ST_SETTLE
  } lnbk_state_e;

  localparam logic [1:0] BURST_NONE = 2'b00;
  localparam logic [1:0] BURST_TONE = 2'b01;
  localparam logic [1:0] BURST_BYTE = 2'b10;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lnbk_us_timer.sv
module lnbk_us_timer #(
  parameter int unsigned TICKS_PER_US = 100,
  parameter int unsigned US_W         = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic [US_W-1:0] target_us,
  output logic            expire
);

  localparam int unsigned PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_US - 1);

  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [US_W-1:0]  us_q, us_nxt;
  logic             cnt_en;

  assign cnt_en = restart | run;

  always_comb begin
    pre_nxt = pre_q;
    us_nxt  = us_q;
    if (restart) begin
      pre_nxt = '0;
      us_nxt  = '0;
    end else if (pre_q == PRE_LAST) begin
      pre_nxt = '0;
      us_nxt  = us_q + 1'b1;
    end else begin
      pre_nxt = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (cnt_en) begin
      pre_q <= pre_nxt;
      us_q  <= us_nxt;
    end
  end

  assign expire = (pre_q == PRE_LAST) && (us_q == target_us - 1'b1);

  // R3
  within_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (us_q < target_us));

endmodule

// File: rtl/lnbk_bit_shifter.sv
module lnbk_bit_shifter #(
  parameter int unsigned MAX_LEN = 10,
  parameter int unsigned LEN_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [LEN_W-1:0]     cap_len,
  input  logic [MAX_LEN*8-1:0] cap_bytes,
  input  logic                 arm_ff,
  input  logic                 step,
  output logic                 cur_bit,
  output logic                 byte_end,
  output logic                 last_byte,
  output logic                 has_bytes
);

  logic [MAX_LEN*8-1:0] buf_q;
  logic [LEN_W-1:0]     len_q, len_nxt, idx_q, idx_nxt;
  logic [3:0]           bit_q, bit_nxt;
  logic                 par_q, par_nxt;
  logic                 ff_q, ff_nxt;
  logic [7:0]           lane_byte, cur_byte;
  logic                 seq_en;

  genvar g;
  generate
    for (g = 0; g < MAX_LEN; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          buf_q[g*8 +: 8] <= '0;
        end else if (capture) begin
          buf_q[g*8 +: 8] <= cap_bytes[g*8 +: 8];
        end
      end
    end
  endgenerate

  always_comb begin
    lane_byte = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      if (idx_q == LEN_W'(k)) lane_byte = buf_q[k*8 +: 8];
    end
  end

  assign cur_byte  = ff_q ? 8'hFF : lane_byte;
  assign byte_end  = (bit_q == 4'd8);
  assign cur_bit   = byte_end ? par_q : cur_byte[3'd7 - bit_q[2:0]];
  assign has_bytes = (len_q != '0);
  assign last_byte = (idx_q == len_q - 1'b1);
  assign seq_en    = capture | arm_ff | step;

  always_comb begin
    len_nxt = len_q;
    idx_nxt = idx_q;
    bit_nxt = bit_q;
    par_nxt = par_q;
    ff_nxt  = ff_q;
    if (capture) begin
      len_nxt = (cap_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cap_len;
      idx_nxt = '0;
      bit_nxt = '0;
      par_nxt = 1'b1;
      ff_nxt  = 1'b0;
    end else if (arm_ff) begin
      bit_nxt = '0;
      par_nxt = 1'b1;
      ff_nxt  = 1'b1;
    end else if (step) begin
      if (byte_end) begin
        bit_nxt = '0;
        par_nxt = 1'b1;
        idx_nxt = idx_q + 1'b1;
      end else begin
        bit_nxt = bit_q + 1'b1;
        par_nxt = par_q ^ cur_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      idx_q <= '0;
      bit_q <= '0;
      par_q <= 1'b1;
      ff_q  <= 1'b0;
    end else if (seq_en) begin
      len_q <= len_nxt;
      idx_q <= idx_nxt;
      bit_q <= bit_nxt;
      par_q <= par_nxt;
      ff_q  <= ff_nxt;
    end
  end

  // R4
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |-> ($countones({cur_byte, par_q}) % 2 == 1));

  // R9
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(MAX_LEN));

endmodule

// File: rtl/lnbk_seq_ctrl.sv
module lnbk_seq_ctrl
  import lnbk_pkg::*;
#(
  parameter int unsigned US_W          = 16,
  parameter int unsigned BIT_SHORT_US  = 500,
  parameter int unsigned BIT_LONG_US   = 1000,
  parameter int unsigned GAP_US        = 16000,
  parameter int unsigned TONE_BURST_US = 12500,
  parameter int unsigned SETTLE_US     = 20000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      burst_sel,
  input  logic            tone_en,
  input  logic            expire,
  input  logic            cur_bit,
  input  logic            byte_end,
  input  logic            last_byte,
  input  logic            has_bytes,
  output logic            capture,
  output logic            arm_ff,
  output logic            step,
  output logic            restart,
  output logic            run,
  output logic [US_W-1:0] target_us,
  output logic            gate,
  output logic            busy,
  output logic            done
);

  localparam logic [US_W-1:0] SHORT_D  = US_W'(BIT_SHORT_US);
  localparam logic [US_W-1:0] LONG_D   = US_W'(BIT_LONG_US);
  localparam logic [US_W-1:0] GAP_D    = US_W'(GAP_US);
  localparam logic [US_W-1:0] TONE_D   = US_W'(TONE_BURST_US);
  localparam logic [US_W-1:0] SETTLE_D = US_W'(SETTLE_US);

  lnbk_state_e state_q, state_nxt;
  logic [1:0]  burst_q, burst_nxt;
  logic        inb_q, inb_nxt;
  logic        gate_q, gate_nxt;
  logic        done_q, done_nxt;

  always_comb begin
    state_nxt = state_q;
    burst_nxt = burst_q;
    inb_nxt   = inb_q;
    capture   = 1'b0;
    arm_ff    = 1'b0;
    step      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_nxt = ST_LEAD;
          capture   = 1'b1;
          burst_nxt = burst_sel;
          inb_nxt   = 1'b0;
        end
      end
      ST_LEAD: begin
        if (expire) state_nxt = has_bytes ? ST_MARK : ST_TRAIL;
      end
      ST_MARK: begin
        if (expire) state_nxt = ST_SPACE;
      end
      ST_SPACE: begin
        if (expire) begin
          if (!byte_end) begin
            step      = 1'b1;
            state_nxt = ST_MARK;
          end else if (inb_q) begin
            state_nxt = ST_SETTLE;
          end else if (last_byte) begin
            state_nxt = ST_TRAIL;
          end else begin
            step      = 1'b1;
            state_nxt = ST_MARK;
          end
        end
      end
      ST_TRAIL: begin
        if (expire) begin
          case (burst_q)
            BURST_TONE: state_nxt = ST_TONE;
            BURST_BYTE: begin
              arm_ff    = 1'b1;
              inb_nxt   = 1'b1;
              state_nxt = ST_MARK;
            end
            default:    state_nxt = ST_IDLE;
          endcase
        end
      end
      ST_TONE: begin
        if (expire) state_nxt = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (expire) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_MARK:   target_us = cur_bit ? SHORT_D : LONG_D;
      ST_SPACE:  target_us = cur_bit ? LONG_D : SHORT_D;
      ST_TONE:   target_us = TONE_D;
      ST_SETTLE: target_us = SETTLE_D;
      default:   target_us = GAP_D;
    endcase
  end

  assign restart  = (state_nxt != state_q);
  assign run      = (state_q != ST_IDLE);
  assign gate_nxt = (state_nxt == ST_MARK) || (state_nxt == ST_TONE) ||
                    ((state_nxt == ST_IDLE) && tone_en);
  assign done_nxt = (state_q != ST_IDLE) && (state_nxt == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      burst_q <= BURST_NONE;
      inb_q   <= 1'b0;
      gate_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      burst_q <= burst_nxt;
      inb_q   <= inb_nxt;
      gate_q  <= gate_nxt;
      done_q  <= done_nxt;
    end
  end

  assign gate = gate_q;
  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start) |=> $stable(burst_q));

  // R5
  quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_LEAD, ST_TRAIL, ST_SETTLE}) |-> !gate_q);

  // R7
  tone_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TONE) |-> gate_q);

endmodule

// File: rtl/lnbk_tone_keyer.sv
module lnbk_tone_keyer
  import lnbk_pkg::*;
#(
  parameter int unsigned TICKS_PER_US  = 100,
  parameter int unsigned MAX_LEN       = 10,
  parameter int unsigned BIT_SHORT_US  = 500,
  parameter int unsigned BIT_LONG_US   = 1000,
  parameter int unsigned GAP_US        = 16000,
  parameter int unsigned TONE_BURST_US = 12500,
  parameter int unsigned SETTLE_US     = 20000,
  localparam int unsigned LEN_W        = $clog2(MAX_LEN + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LEN_W-1:0]     msg_len,
  input  logic [MAX_LEN*8-1:0] msg_bytes,
  input  logic [1:0]           burst_sel,
  input  logic                 tone_en,
  output logic                 gate,
  output logic                 busy,
  output logic                 done
);

  localparam int unsigned MAX_US = max2(max2(max2(BIT_SHORT_US, BIT_LONG_US),
                                             max2(GAP_US, TONE_BURST_US)), SETTLE_US);
  localparam int unsigned US_W   = $clog2(MAX_US + 1);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            capture, arm_ff, step, restart, run, expire;
  logic            cur_bit, byte_end, last_byte, has_bytes;
  logic [US_W-1:0] target_us;
  logic            past_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lnbk_seq_ctrl #(
    .US_W          (US_W),
    .BIT_SHORT_US  (BIT_SHORT_US),
    .BIT_LONG_US   (BIT_LONG_US),
    .GAP_US        (GAP_US),
    .TONE_BURST_US (TONE_BURST_US),
    .SETTLE_US     (SETTLE_US)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .burst_sel (burst_sel),
    .tone_en   (tone_en),
    .expire    (expire),
    .cur_bit   (cur_bit),
    .byte_end  (byte_end),
    .last_byte (last_byte),
    .has_bytes (has_bytes),
    .capture   (capture),
    .arm_ff    (arm_ff),
    .step      (step),
    .restart   (restart),
    .run       (run),
    .target_us (target_us),
    .gate      (gate),
    .busy      (busy),
    .done      (done)
  );

  lnbk_us_timer #(
    .TICKS_PER_US (TICKS_PER_US),
    .US_W         (US_W)
  ) timer_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .restart   (restart),
    .run       (run),
    .target_us (target_us),
    .expire    (expire)
  );

  lnbk_bit_shifter #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
  ) shift_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture   (capture),
    .cap_len   (msg_len),
    .cap_bytes (msg_bytes),
    .arm_ff    (arm_ff),
    .step      (step),
    .cur_bit   (cur_bit),
    .byte_end  (byte_end),
    .last_byte (last_byte),
    .has_bytes (has_bytes)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) past_ok_q <= 1'b0;
    else            past_ok_q <= 1'b1;
  end

  // R1
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (past_ok_q && !busy) |-> (gate == $past(tone_en)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/lnbk_tone_keyer_tb_top.sv
module lnbk_tone_keyer_tb_top;

  localparam int TPU    = 2;
  localparam int MAXL   = 3;
  localparam int SHORT  = 3;
  localparam int LONG   = 6;
  localparam int GAP    = 20;
  localparam int TONE   = 25;
  localparam int SETTLE = 30;
  localparam int LW     = $clog2(MAXL + 1) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [LW-1:0]   msg_len = '0;
  logic [MAXL*8-1:0] msg_bytes = '0;
  logic [1:0]      burst_sel = 2'b00;
  logic            tone_en = 1'b0;
  logic            gate, busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit exp_q[$];

  always #5 clk = ~clk;

  lnbk_tone_keyer #(
    .TICKS_PER_US (TPU), .MAX_LEN (MAXL), .BIT_SHORT_US (SHORT),
    .BIT_LONG_US (LONG), .GAP_US (GAP), .TONE_BURST_US (TONE), .SETTLE_US (SETTLE)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start), .msg_len (msg_len),
    .msg_bytes (msg_bytes), .burst_sel (burst_sel), .tone_en (tone_en),
    .gate (gate), .busy (busy), .done (done)
  );

  task automatic chk(input string tag, input bit ok, input int act, input int exp_v, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  function automatic void add(input bit v, input int us);
    for (int i = 0; i < us * TPU; i++) exp_q.push_back(v);
  endfunction

  function automatic void add_byte(input logic [7:0] b);
    bit p = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      add(1'b1, b[i] ? SHORT : LONG);
      add(1'b0, b[i] ? LONG : SHORT);
      p ^= b[i];
    end
    add(1'b1, p ? SHORT : LONG);
    add(1'b0, p ? LONG : SHORT);
  endfunction

  task automatic run_msg(input string tag, input int len, input logic [MAXL*8-1:0] bytes,
                         input logic [1:0] bsel, input bit tone, input bit disturb);
    int n;
    int miss;
    int first_i;
    n = (len > MAXL) ? MAXL : len;
    exp_q.delete();
    add(1'b0, GAP);
    for (int k = 0; k < n; k++) add_byte(bytes[k*8 +: 8]);
    add(1'b0, GAP);
    if (bsel == 2'b01) begin add(1'b1, TONE); add(1'b0, SETTLE); end
    if (bsel == 2'b10) begin add_byte(8'hFF); add(1'b0, SETTLE); end
    @(negedge clk);
    msg_len = LW'(len); msg_bytes = bytes; burst_sel = bsel; tone_en = tone; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    miss = 0; first_i = -1;
    for (int i = 0; i < exp_q.size(); i++) begin
      if (gate !== exp_q[i] || busy !== 1'b1) begin
        if (miss == 0) first_i = i;
        miss++;
      end
      if (disturb && i == 5) begin
        start = 1'b1; msg_bytes = ~bytes; msg_len = '0; burst_sel = ~bsel; tone_en = ~tone;
      end
      if (disturb && i == 6) start = 1'b0;
      @(negedge clk);
    end
    if (miss != 0)
      chk(tag, 1'b0, miss, 0, $sformatf("waveform mismatches (first at cycle %0d)", first_i));
    else
      chk(tag, 1'b1, 0, 0, "waveform");
    // R10: done in the first idle cycle, gate back to tone_en
    chk("R10", done === 1'b1 && busy === 1'b0, {done, busy}, 2, "done/busy at end");
    chk("R1", gate === tone_en, gate, tone_en, "gate after end");
    @(negedge clk);
    chk("R10", done === 1'b0, done, 0, "done one cycle");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", gate === 1'b0 && busy === 1'b0 && done === 1'b0, {gate, busy, done}, 0, "reset outputs");
    tone_en = 1'b1;
    @(negedge clk);
    chk("R1", gate === 1'b1, gate, 1, "idle tone on");
    tone_en = 1'b0;
    @(negedge clk);
    chk("R1", gate === 1'b0, gate, 0, "idle tone off");

    // R3 R4: every single-byte value
    for (int v = 0; v < 256; v++)
      run_msg((v % 2) ? "R3" : "R4", 1, {16'h0000, 8'(v)}, 2'b00, v[3], 1'b0);

    // R5 R6 R7 R8 R11: length x burst sweep
    for (int l = 0; l <= MAXL; l++) begin
      for (int b = 0; b < 4; b++) begin
        string tg;
        if (l == 0)      tg = "R11";
        else if (b == 1) tg = "R7";
        else if (b == 2) tg = "R6";
        else if (b == 3) tg = "R8";
        else             tg = "R5";
        run_msg(tg, l, 24'hC35A81 ^ 24'(l * 37 + b), 2'(b), b[0], 1'b0);
      end
    end

    // R9: lengths above the maximum
    for (int l = MAXL + 1; l < (1 << LW); l++)
      run_msg("R9", l, 24'h96E10F, 2'b00, 1'b0, 1'b0);

    // R2: start, data and tone changes while busy
    run_msg("R2", 2, 24'h00A53C, 2'b10, 1'b1, 1'b1);
    run_msg("R2", 3, 24'h7E0118, 2'b01, 1'b0, 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule